// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Hold Handshake

The block keeps wall-clock time and date in packed BCD: seconds, minutes, hours in 24-hour form, a day-of-week index, day of month, month and a two-digit year spanning 2000 to 2099. It advances from a 32.768 kHz tick strobe that arrives as a one-cycle pulse in the system clock domain. A prescaler divides the strobe down to one step per second. The step carries through the whole BCD chain in a single clock edge, so a read of the capture fields never shows a half-updated date.

Software changes the time in four steps. It writes the hold request. It polls until the stopped flag appears, which happens two slow ticks later. It writes the new values into the setting fields, then writes zero to the hold register. Leaving the held state copies the setting fields into the counter and restarts the prescaler. If the hold is withdrawn before the counter has stopped, the load is abandoned and counting resumes from the frozen values.

The hold controller has four states, named HS_RUN, HS_WAIT1, HS_WAIT2 and HS_HELD. Its transitions are:
- HS_RUN to HS_WAIT1 on a hold request.
- HS_WAIT1 to HS_WAIT2 on a tick.
- HS_WAIT2 to HS_HELD on a tick.
- HS_WAIT1 or HS_WAIT2 back to HS_RUN when the hold is withdrawn. This is the abort path and loads nothing.
- HS_HELD to HS_RUN on release, with a load of the setting fields.

Register map:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 count enable, bit 1 24-hour mode flag |
| 1 | Hold: write bit 0 = 1 to request, write bit 0 = 0 to release; reads bit 0 wait, bit 1 stopped |
| 2..8 | Setting fields: seconds, minutes, hours, weekday, day, month, year |
| 9..15 | Capture fields, in the same order as the setting fields |

Top module: `rtcal_top`

## Requirements
- R1: After reset the control register reads 0x00 and the hold register reads 0x00. The setting fields and the capture fields both read 00:00:00, weekday 0, day 0x01, month 0x01, year 0x00.
- R2: While in HS_RUN with control bit 0 set, the seconds field advances by one after every TICKS_PER_SEC ticks. With control bit 0 clear, ticks leave the capture fields unchanged.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: Each day carry increments the weekday, which wraps from 6 to 0.
- R5: On a day carry, the day returns to 0x01 once it has reached the month's length, and the month increments. April, June, September and November have 30 days; the other months except February have 31. Month 0x12 wraps to 0x01 and increments the year, and year 0x99 wraps to 0x00.
- R6: February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R7: Writing bit 0 = 1 to the hold register makes it read 0x01 at once and stops counting. It reads 0x03 after the second tick that follows, and the capture fields do not move while it is held.
- R8: Writing 0 to the hold register while it reads 0x03 copies all seven setting fields into the capture fields and returns the hold register to 0x00. It also restarts the prescaler, so the next second comes after exactly TICKS_PER_SEC ticks.
- R9: Writing 0 to the hold register before the stopped bit is set returns it to 0x00 without loading. Counting resumes from the frozen capture values.
- R10: Writes to the setting fields while running do not change the capture fields, and writes to the capture addresses are ignored.
- R11: Control bits 1:0 read back as written, and each setting address reads back its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |

## Verification
On every cycle, the assertions check three things. A capture field changes only on a one-second step or on a load. A load reproduces the setting fields exactly. The stopped flag only rises on a tick. They also check that each step coincides with a tick and that the seconds wrap lands on zero. Month lengths, leap years, the weekday wrap, the abort path and the prescaler restart can only be shown by the bench scenarios. Those scenarios load the last day of every month across several leap and common years, sweep every hour and weekday across midnight, and walk the hold handshake through its timing.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

    localparam int NFIELD = 7;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_WDAY = 3;
    localparam int F_MDAY = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    localparam logic [3:0] A_CTRL     = 4'd0;
    localparam logic [3:0] A_HOLD     = 4'd1;
    localparam logic [3:0] A_SET_BASE = 4'd2;
    localparam logic [3:0] A_CNT_BASE = 4'd9;

    typedef logic [NFIELD-1:0][7:0] cal_t;

    localparam cal_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_WAIT1 = 2'd1,
        HS_WAIT2 = 2'd2,
        HS_HELD  = 2'd3
    } hold_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when an even tens digit meets 0/4/8
    // or an odd tens digit meets 2/6.
    function automatic logic year_is_leap(input logic [7:0] yr);
        if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcal_presc.sv
module rtcal_presc #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic sec_step
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] div_q;

    assign sec_step = tick && run && (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (restart)        div_q <= '0;
        else if (tick && run)    div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/rtcal_hold.sv
module rtcal_hold
    import rtcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_set,
    input  logic hold_clr,
    output logic waiting,
    output logic stopped,
    output logic running,
    output logic load_p
);
    hold_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_RUN:   if (hold_set) st_d = HS_WAIT1;
            HS_WAIT1: if (hold_clr) st_d = HS_RUN;
                      else if (tick) st_d = HS_WAIT2;
            HS_WAIT2: if (hold_clr) st_d = HS_RUN;
                      else if (tick) st_d = HS_HELD;
            HS_HELD:  if (hold_clr) st_d = HS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        waiting = 1'b1;
        stopped = 1'b0;
        running = 1'b0;
        load_p  = 1'b0;
        unique case (st_q)
            HS_RUN: begin
                waiting = 1'b0;
                running = 1'b1;
            end
            HS_WAIT1, HS_WAIT2: ;
            HS_HELD: begin
                stopped = 1'b1;
                load_p  = hold_clr;
            end
        endcase
    end
endmodule

// File: rtl/rtcal_count.sv
module rtcal_count
    import rtcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  cal_t set_i,
    output cal_t cnt_o
);
    cal_t cnt_q, nxt;

    always_comb begin
        nxt = cnt_q;
        if (cnt_q[F_SEC] != 8'h59) begin
            nxt[F_SEC] = bcd_inc(cnt_q[F_SEC]);
        end else begin
            nxt[F_SEC] = 8'h00;
            if (cnt_q[F_MIN] != 8'h59) begin
                nxt[F_MIN] = bcd_inc(cnt_q[F_MIN]);
            end else begin
                nxt[F_MIN] = 8'h00;
                if (cnt_q[F_HOUR] != 8'h23) begin
                    nxt[F_HOUR] = bcd_inc(cnt_q[F_HOUR]);
                end else begin
                    nxt[F_HOUR] = 8'h00;
                    nxt[F_WDAY] = (cnt_q[F_WDAY] >= 8'h06) ? 8'h00 : bcd_inc(cnt_q[F_WDAY]);
                    if (cnt_q[F_MDAY] < month_len(cnt_q[F_MON], cnt_q[F_YEAR])) begin
                        nxt[F_MDAY] = bcd_inc(cnt_q[F_MDAY]);
                    end else begin
                        nxt[F_MDAY] = 8'h01;
                        if (cnt_q[F_MON] < 8'h12) begin
                            nxt[F_MON] = bcd_inc(cnt_q[F_MON]);
                        end else begin
                            nxt[F_MON]  = 8'h01;
                            nxt[F_YEAR] = (cnt_q[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cnt_q[F_YEAR]);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= CAL_RESET;
        else if (load) cnt_q <= set_i;
        else if (step) cnt_q <= nxt;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rtcal_top.sv
module rtcal_top
    import rtcal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    logic [1:0] ctrl_q;
    cal_t       set_q, cnt_q;
    logic       waiting, stopped, running, load_p, sec_p, run_w;
    logic       hold_set, hold_clr;
    logic [2:0] sidx, cidx;
    logic       is_set_addr, is_cnt_addr;

    assign sidx        = 3'(addr - A_SET_BASE);
    assign cidx        = 3'(addr - A_CNT_BASE);
    assign is_set_addr = (addr >= A_SET_BASE) && (addr < A_CNT_BASE);
    assign is_cnt_addr = (addr >= A_CNT_BASE);
    assign hold_set    = wr_en && (addr == A_HOLD) && wdata[0];
    assign hold_clr    = wr_en && (addr == A_HOLD) && !wdata[0];
    assign run_w       = running && ctrl_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
            set_q  <= CAL_RESET;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata[1:0];
            if (is_set_addr)    set_q[sidx] <= wdata;
        end
    end

    rtcal_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .hold_set (hold_set),
        .hold_clr (hold_clr),
        .waiting  (waiting),
        .stopped  (stopped),
        .running  (running),
        .load_p   (load_p)
    );

    rtcal_presc #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .run      (run_w),
        .restart  (load_p),
        .sec_step (sec_p)
    );

    rtcal_count u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sec_p),
        .load  (load_p),
        .set_i (set_q),
        .cnt_o (cnt_q)
    );

    always_comb begin
        if (addr == A_CTRL)      rdata = {6'b0, ctrl_q};
        else if (addr == A_HOLD) rdata = {6'b0, stopped, waiting};
        else if (is_set_addr)    rdata = set_q[sidx];
        else if (is_cnt_addr)    rdata = cnt_q[cidx];
        else                     rdata = 8'h00;
    end
endmodule

// File: rtl/rtcal_chk.sv
module rtcal_chk
    import rtcal_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic tick_32k,
    input logic sec_p,
    input logic load_p,
    input logic stopped,
    input cal_t set_q,
    input cal_t cnt_q
);
    // R7: the capture fields move only on a second step or a load
    a_r7_change_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> $past(sec_p || load_p));

    // R2: a second step is always caused by a slow tick
    a_r2_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_p |-> tick_32k);

    // R3: seconds wrap lands on zero
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_p && cnt_q[F_SEC] == 8'h59) |=> (cnt_q[F_SEC] == 8'h00));

    // R7: the stopped flag rises only after a tick edge
    a_r7_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(tick_32k));

    // R8: a release load copies every setting field
    a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load_p |=> (cnt_q == $past(set_q)));
endmodule

bind rtcal_top rtcal_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_32k (tick_32k),
    .sec_p    (sec_p),
    .load_p   (load_p),
    .stopped  (stopped),
    .set_q    (set_q),
    .cnt_q    (cnt_q)
);

// File: tb/sim_rtcal_top.sv
`timescale 1ns/1ps
module sim_rtcal_top;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int nvec = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    rtcal_top #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] pack(input int s, input int mi, input int h,
                                         input int w, input int d, input int mo, input int y);
        return {bcd(y), bcd(mo), bcd(d), bcd(w), bcd(h), bcd(mi), bcd(s)};
    endfunction

    task automatic chk(input string req, input logic [55:0] got, input logic [55:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_32k = 1'b1;
            @(negedge clk); tick_32k = 1'b0;
        end
    endtask

    task automatic rd_block(input logic [3:0] base, output logic [55:0] v);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(base + 4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic write_set(input logic [55:0] v);
        for (int i = 0; i < 7; i++) wr(4'd2 + 4'(i), v[i*8 +: 8]);
    endtask

    task automatic load_time(input logic [55:0] v);
        wr(4'd1, 8'h01);
        tick_n(2);
        write_set(v);
        wr(4'd1, 8'h00);
    endtask

    logic [55:0] got;
    logic [7:0]  b;

    initial begin
        #1_500_000;
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, b); chk("R1 ctrl", 56'(b), 56'h0);
        rd(4'd1, b); chk("R1 hold", 56'(b), 56'h0);
        rd_block(4'd9, got); chk("R1 capture", got, pack(0,0,0,0,1,1,0));
        rd_block(4'd2, got); chk("R1 setting", got, pack(0,0,0,0,1,1,0));

        // R2 disabled counter ignores ticks
        tick_n(3 * TPS);
        rd_block(4'd9, got); chk("R2 disabled", got, pack(0,0,0,0,1,1,0));

        // R11 control readback
        wr(4'd0, 8'h03);
        rd(4'd0, b); chk("R11 ctrl", 56'(b), 56'h3);

        // R2/R3 seconds and minutes sweep
        load_time(pack(0,0,5,2,10,6,21));
        for (int i = 1; i <= 130; i++) begin
            tick_n(TPS);
            rd_block(4'd9, got);
            chk("R3 sec/min sweep", got, pack(i % 60, i / 60, 5, 2, 10, 6, 21));
        end

        // R8 prescaler restart: TPS-1 ticks do not step
        load_time(pack(30,20,10,1,5,3,12));
        tick_n(TPS - 1);
        rd_block(4'd9, got); chk("R8 no early step", got, pack(30,20,10,1,5,3,12));
        tick_n(1);
        rd_block(4'd9, got); chk("R8 step after TPS", got, pack(31,20,10,1,5,3,12));

        // R3 every hour across its minute boundary
        for (int h = 0; h < 24; h++) begin
            load_time(pack(59,59,h,3,15,7,40));
            tick_n(TPS);
            rd_block(4'd9, got);
            if (h < 23) chk("R3 hour carry", got, pack(0,0,h+1,3,15,7,40));
            else        chk("R3 midnight", got, pack(0,0,0,4,16,7,40));
        end

        // R4 weekday wrap
        for (int w = 0; w < 7; w++) begin
            load_time(pack(59,59,23,w,3,8,55));
            tick_n(TPS);
            rd_block(4'd9, got);
            chk("R4 weekday", got, pack(0,0,0,(w+1)%7,4,8,55));
        end

        // R5/R6 month lengths over leap and common years
        for (int k = 0; k < 6; k++) begin
            int y;
            case (k)
                0: y = 0;  1: y = 1;  2: y = 4;
                3: y = 23; 4: y = 96; default: y = 99;
            endcase
            for (int m = 1; m <= 12; m++) begin
                int l;
                l = mdays(m, y);
                load_time(pack(59,59,23,3,l-1,m,y));
                tick_n(TPS);
                rd_block(4'd9, got);
                chk((m == 2) ? "R6 feb before end" : "R5 before end", got, pack(0,0,0,4,l,m,y));
                load_time(pack(59,59,23,3,l,m,y));
                tick_n(TPS);
                rd_block(4'd9, got);
                chk((m == 2) ? "R6 feb rollover" : "R5 month rollover", got,
                    pack(0,0,0,4,1,(m % 12) + 1, (m == 12) ? (y + 1) % 100 : y));
            end
        end

        // R7 hold handshake timing and freeze
        load_time(pack(10,20,8,1,2,2,30));
        wr(4'd1, 8'h01);
        rd(4'd1, b); chk("R7 wait immediate", 56'(b), 56'h1);
        tick_n(1);
        rd(4'd1, b); chk("R7 one tick", 56'(b), 56'h1);
        tick_n(1);
        rd(4'd1, b); chk("R7 stopped", 56'(b), 56'h3);
        tick_n(3 * TPS);
        rd_block(4'd9, got); chk("R7 frozen", got, pack(10,20,8,1,2,2,30));

        // R8 release loads setting fields
        write_set(pack(45,44,13,5,27,9,88));
        rd_block(4'd9, got); chk("R7 frozen after set", got, pack(10,20,8,1,2,2,30));
        wr(4'd1, 8'h00);
        rd(4'd1, b); chk("R8 hold cleared", 56'(b), 56'h0);
        rd_block(4'd9, got); chk("R8 loaded", got, pack(45,44,13,5,27,9,88));
        rd_block(4'd2, got); chk("R11 setting readback", got, pack(45,44,13,5,27,9,88));

        // R9 abort before stopped
        wr(4'd1, 8'h01);
        tick_n(1);
        write_set(pack(1,2,3,4,5,6,7));
        wr(4'd1, 8'h00);
        rd(4'd1, b); chk("R9 hold cleared", 56'(b), 56'h0);
        rd_block(4'd9, got); chk("R9 no load", got, pack(45,44,13,5,27,9,88));
        tick_n(TPS);
        rd_block(4'd9, got); chk("R9 resumes", got, pack(46,44,13,5,27,9,88));

        // R10 setting and capture writes while running
        wr(4'd2, 8'h33);
        wr(4'd9, 8'h11);
        wr(4'd15, 8'h55);
        rd_block(4'd9, got); chk("R10 capture untouched", got, pack(46,44,13,5,27,9,88));
        rd(4'd2, b); chk("R11 sec setting", 56'(b), 56'h33);

        // R2 enable cleared stops counting
        wr(4'd0, 8'h02);
        tick_n(2 * TPS);
        rd_block(4'd9, got); chk("R2 enable off", got, pack(46,44,13,5,27,9,88));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule